// File: doc/BRIEF.md
# Locked Relocatable Configuration Port

This block is the configuration front end of an ISA-style audio controller. Software finds it through a fixed, write-only unlock port. After the correct key byte is written there, a two-address window (an index port and a data port right after it) gives access to twelve 8-bit control registers. While unlocked, a write to the unlock port moves that window to a new base and can also remove the key requirement altogether.

The control registers are decoded into the resources the rest of the controller uses. These are the legacy audio I/O base, the codec I/O base, the joystick port enable, the DMA channel, the IRQ line, the MIDI port base and IRQ, and two codec mode flags. All of these are held in registers, so downstream logic sees stable values. The host side is a plain address, write-data, read-strobe and write-strobe bus. Read data is returned combinationally while the read strobe is high.

Top module: `audcfg_port`

## Requirements
- R1: After reset the window is locked and the key is required. The index port is at 0x0E0E and the data port at 0x0E0F. The stored index is 0. Registers 0 to 11 hold 0x00, 0x00, 0x2A, 0x10, 0x00, 0x81 and then zeros. The decoded outputs match those register values.
- R2: Writing 0xE4 to address 0x0F8F leaves the window unlocked. This holds whether the window was locked or unlocked before the write. A different byte written there while locked keeps it locked.
- R3: A write to 0x0F8F while unlocked moves the window. The index port becomes 0x0E0E + 16 × (byte bits 4:0). A 1 in bit 7 removes the key requirement and a 0 restores it. The window is then locked, unless the byte is 0xE4 (see R2).
- R4: The window can be used only when it is unlocked or the key requirement is removed. At all other times, reads of the index and data ports return 0xFF and writes to them change nothing. Any read that hits no open port also returns 0xFF, and this includes reads of 0x0F8F.
- R5: A write to the index port stores the byte minus one, modulo 256. A read of the index port returns the stored value.
- R6: Any read or write of the data port locks the window, except when the index port is at 0x0F8E.
- R7: A data-port read returns the addressed register for indices 0 to 9 and 11. Index 10 returns bit 4 of `codec_status` in bit 2 and zeros elsewhere. Any other index returns 0xFF. Data writes to index 10, or to indices 12 and above, are dropped.
- R8: Register 0 decodes as follows. Bit 7 gives a legacy base of 0x240 when set and 0x220 when clear. Bits 5:4 give a codec base of 0x530, 0xE80, 0xF40 or 0x604 for codes 0 to 3. Bit 0 set turns `game_en` off.
- R9: Register 2 decodes as follows. Bits 1:0 give no DMA for code 0, and DMA 0, 1 or 3 for codes 1 to 3. Bits 5:3 give no IRQ for code 0; codes 1 to 4 give IRQ 7, 9, 10 or 11, and codes 5 to 7 give IRQ 5.
- R10: Register 5 decodes as follows. Bits 4:3 give MIDI IRQ 9, 10, 5 or 7. Bits 6:5 give a MIDI base of 0x330, 0x320, 0x310 or 0x300. Bit 1 drives `codec_mode`. Bit 5 of register 4 drives `ext_mode`.
- R11: The decoded outputs change on the clock edge that captures a data write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| codec_status | input | 8 | Status byte from the codec; bit 4 is reported |
| legacy_base | output | 16 | Legacy audio I/O base |
| codec_base | output | 16 | Codec I/O base |
| game_en | output | 1 | Joystick port enabled at 0x200 |
| dma_on | output | 1 | A DMA channel is selected |
| dma_ch | output | 2 | Selected DMA channel |
| irq_on | output | 1 | An IRQ line is selected |
| irq_no | output | 4 | Selected IRQ number |
| midi_irq | output | 4 | MIDI port IRQ number |
| midi_base | output | 16 | MIDI port I/O base |
| codec_mode | output | 1 | Codec mode selected instead of legacy mode |
| ext_mode | output | 1 | Extended codec mode enabled |

## Verification
The hardest state to reach from the ports is a window sitting at 0x0F8E. There the data port is the same address as the unlock port, so data accesses do not lock the window, and every data write is also a relocation. The bench reaches it by writing 0x18 and then the key to 0x0F8F. It then reads the data port several times and expects each read to return valid data. A second hard case is the key written while already unlocked: it relocates the window to 0x0E4E, removes the key requirement and still leaves the window unlocked. A random phase mixes keys, arbitrary unlock-port bytes, index and data traffic, and reads at the current window. This drives the window through many positions, and a bench model predicts every byte read back.

// File: rtl/audcfg_pkg.sv
package audcfg_pkg;

  localparam int unsigned CFG_AW = 16;
  localparam int unsigned CFG_DW = 8;

  typedef struct packed {
    logic [CFG_AW-1:0] legacy_base;
    logic [CFG_AW-1:0] codec_base;
    logic              game_en;
    logic              dma_on;
    logic [1:0]        dma_ch;
    logic              irq_on;
    logic [3:0]        irq_no;
    logic [3:0]        midi_irq;
    logic [CFG_AW-1:0] midi_base;
    logic              codec_mode;
    logic              ext_mode;
  } res_sel_t;

  // power-up contents of the control registers
  function automatic logic [CFG_DW-1:0] reg_reset(int unsigned i);
    case (i)
      2:       return 8'h2A;
      3:       return 8'h10;
      5:       return 8'h81;
      default: return 8'h00;
    endcase
  endfunction

  function automatic res_sel_t cfg_decode(logic [CFG_DW-1:0] map_r,
                                          logic [CFG_DW-1:0] res_r,
                                          logic [CFG_DW-1:0] xm_r,
                                          logic [CFG_DW-1:0] midi_r);
    res_sel_t s;
    s.legacy_base = map_r[7] ? 16'h0240 : 16'h0220;
    case (map_r[5:4])
      2'd0:    s.codec_base = 16'h0530;
      2'd1:    s.codec_base = 16'h0E80;
      2'd2:    s.codec_base = 16'h0F40;
      default: s.codec_base = 16'h0604;
    endcase
    s.game_en = ~map_r[0];
    s.dma_on  = (res_r[1:0] != 2'd0);
    case (res_r[1:0])
      2'd2:    s.dma_ch = 2'd1;
      2'd3:    s.dma_ch = 2'd3;
      default: s.dma_ch = 2'd0;
    endcase
    s.irq_on = (res_r[5:3] != 3'd0);
    case (res_r[5:3])
      3'd0:    s.irq_no = 4'd0;
      3'd1:    s.irq_no = 4'd7;
      3'd2:    s.irq_no = 4'd9;
      3'd3:    s.irq_no = 4'd10;
      3'd4:    s.irq_no = 4'd11;
      default: s.irq_no = 4'd5;
    endcase
    case (midi_r[4:3])
      2'd0:    s.midi_irq = 4'd9;
      2'd1:    s.midi_irq = 4'd10;
      2'd2:    s.midi_irq = 4'd5;
      default: s.midi_irq = 4'd7;
    endcase
    s.midi_base  = 16'h0330 - {10'd0, midi_r[6:5], 4'd0};
    s.codec_mode = midi_r[1];
    s.ext_mode   = xm_r[5];
    return s;
  endfunction

endpackage

// File: rtl/audcfg_unlock.sv
module audcfg_unlock
  import audcfg_pkg::*;
#(
  parameter logic [CFG_DW-1:0] CHIP_ID    = 8'hE4,
  parameter logic [CFG_AW-1:0] BASE_ORG   = 16'h0E0E,
  parameter logic [CFG_AW-1:0] FIXED_BASE = 16'h0F8E,
  parameter int unsigned       FIELD_W    = 5,
  parameter int unsigned       STEP_SH    = 4,
  parameter int unsigned       BYPASS_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_wr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic              data_touch,
  output logic              unlocked,
  output logic              pw_req,
  output logic [CFG_AW-1:0] idx_base
);

  logic               unl_q, unl_d;
  logic               req_q, req_d;
  logic [FIELD_W-1:0] fld_q, fld_d;
  logic [CFG_DW-1:0]  last_q, last_d;
  logic               st_en;

  assign idx_base = BASE_ORG + (CFG_AW'(fld_q) << STEP_SH);
  assign st_en    = pw_wr | data_touch;

  always_comb begin
    unl_d  = unl_q;
    req_d  = req_q;
    fld_d  = fld_q;
    last_d = last_q;
    if (pw_wr) begin
      if (unl_q) begin
        fld_d = wdata[FIELD_W-1:0];
        req_d = ~wdata[BYPASS_BIT];
        unl_d = 1'b0;
      end
      // the key reopens the window even right after a relocation
      if (wdata == CHIP_ID)
        unl_d = 1'b1;
      else if (last_q != CHIP_ID)
        unl_d = 1'b0;
      last_d = wdata;
    end
    if (data_touch && (idx_base != FIXED_BASE))
      unl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q  <= 1'b0;
      req_q  <= 1'b1;
      fld_q  <= '0;
      last_q <= '0;
    end else if (st_en) begin
      unl_q  <= unl_d;
      req_q  <= req_d;
      fld_q  <= fld_d;
      last_q <= last_d;
    end
  end

  assign unlocked = unl_q;
  assign pw_req   = req_q;

endmodule

// File: rtl/audcfg_regfile.sv
module audcfg_regfile
  import audcfg_pkg::*;
#(
  parameter int unsigned NREGS  = 12,
  parameter int unsigned RO_IDX = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idx_wr,
  input  logic                          data_wr,
  input  logic [CFG_DW-1:0]             wdata,
  output logic [CFG_DW-1:0]             idx_q,
  output logic [NREGS-1:0][CFG_DW-1:0]  regs_q,
  output logic [NREGS-1:0][CFG_DW-1:0]  regs_nxt
);

  logic [CFG_DW-1:0] idx_d;

  assign idx_d = wdata - CFG_DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= idx_d;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == RO_IDX) begin : g_ro
      assign regs_q[g]   = reg_reset(g);
      assign regs_nxt[g] = reg_reset(g);
    end else begin : g_rw
      logic              wr_en;
      logic [CFG_DW-1:0] r_q;
      assign wr_en       = data_wr && (idx_q == CFG_DW'(g));
      assign regs_nxt[g] = wr_en ? wdata : r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     r_q <= reg_reset(g);
        else if (wr_en) r_q <= wdata;
      end
      assign regs_q[g] = r_q;
    end
  end

endmodule

// File: rtl/audcfg_decode.sv
module audcfg_decode
  import audcfg_pkg::*;
#(
  parameter int unsigned NREGS     = 12,
  parameter int unsigned IDX_MAP   = 0,
  parameter int unsigned IDX_RES   = 2,
  parameter int unsigned IDX_XMODE = 4,
  parameter int unsigned IDX_MIDI  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_en,
  input  logic [NREGS-1:0][CFG_DW-1:0] regs_nxt,
  output res_sel_t                     sel_q
);

  res_sel_t sel_d;
  logic     unused_regs;

  assign unused_regs = ^regs_nxt;
  assign sel_d = cfg_decode(regs_nxt[IDX_MAP], regs_nxt[IDX_RES],
                            regs_nxt[IDX_XMODE], regs_nxt[IDX_MIDI]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= cfg_decode(reg_reset(IDX_MAP), reg_reset(IDX_RES),
                          reg_reset(IDX_XMODE), reg_reset(IDX_MIDI));
    else if (upd_en)
      sel_q <= sel_d;
  end

endmodule

// File: rtl/audcfg_port.sv
module audcfg_port
  import audcfg_pkg::*;
#(
  parameter logic [CFG_AW-1:0] PW_ADDR    = 16'h0F8F,
  parameter logic [CFG_DW-1:0] CHIP_ID    = 8'hE4,
  parameter logic [CFG_AW-1:0] BASE_ORG   = 16'h0E0E,
  parameter logic [CFG_AW-1:0] FIXED_BASE = 16'h0F8E,
  parameter int unsigned       NREGS      = 12,
  parameter int unsigned       RO_IDX     = 10,
  parameter int unsigned       STAT_BIT   = 4,
  parameter int unsigned       STAT_POS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] bus_addr,
  input  logic [CFG_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [CFG_DW-1:0] bus_rdata,
  input  logic [CFG_DW-1:0] codec_status,
  output logic [CFG_AW-1:0] legacy_base,
  output logic [CFG_AW-1:0] codec_base,
  output logic              game_en,
  output logic              dma_on,
  output logic [1:0]        dma_ch,
  output logic              irq_on,
  output logic [3:0]        irq_no,
  output logic [3:0]        midi_irq,
  output logic [CFG_AW-1:0] midi_base,
  output logic              codec_mode,
  output logic              ext_mode
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic              unlocked, pw_req, access;
  logic [CFG_AW-1:0] idx_base, dat_addr;
  logic              hit_idx, hit_dat, pw_wr, data_touch, idx_wr, data_wr;
  logic [CFG_DW-1:0] idx_q;
  logic [NREGS-1:0][CFG_DW-1:0] regs_q, regs_nxt;
  res_sel_t          sel_q;
  logic              unused_status;

  assign dat_addr   = idx_base + CFG_AW'(1);
  assign hit_idx    = (bus_addr == idx_base);
  assign hit_dat    = (bus_addr == dat_addr);
  assign access     = unlocked | ~pw_req;
  assign pw_wr      = bus_wr && (bus_addr == PW_ADDR);
  assign data_touch = (bus_rd | bus_wr) && hit_dat;
  assign idx_wr     = bus_wr && hit_idx && access;
  assign data_wr    = bus_wr && hit_dat && access;

  audcfg_unlock #(
    .CHIP_ID   (CHIP_ID),
    .BASE_ORG  (BASE_ORG),
    .FIXED_BASE(FIXED_BASE)
  ) unlock_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pw_wr     (pw_wr),
    .wdata     (bus_wdata),
    .data_touch(data_touch),
    .unlocked  (unlocked),
    .pw_req    (pw_req),
    .idx_base  (idx_base)
  );

  audcfg_regfile #(
    .NREGS (NREGS),
    .RO_IDX(RO_IDX)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .idx_wr  (idx_wr),
    .data_wr (data_wr),
    .wdata   (bus_wdata),
    .idx_q   (idx_q),
    .regs_q  (regs_q),
    .regs_nxt(regs_nxt)
  );

  audcfg_decode #(
    .NREGS(NREGS)
  ) dec_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd_en  (data_wr),
    .regs_nxt(regs_nxt),
    .sel_q   (sel_q)
  );

  // read path: open window only, everything else floats high
  always_comb begin
    bus_rdata = '1;
    if (bus_rd && access) begin
      if (hit_idx) begin
        bus_rdata = idx_q;
      end else if (hit_dat) begin
        if (idx_q == CFG_DW'(RO_IDX))
          bus_rdata = CFG_DW'(codec_status[STAT_BIT]) << STAT_POS;
        else if (idx_q < CFG_DW'(NREGS))
          bus_rdata = regs_q[idx_q[$clog2(NREGS)-1:0]];
      end
    end
  end

  assign unused_status = ^codec_status;

  assign legacy_base = sel_q.legacy_base;
  assign codec_base  = sel_q.codec_base;
  assign game_en     = sel_q.game_en;
  assign dma_on      = sel_q.dma_on;
  assign dma_ch      = sel_q.dma_ch;
  assign irq_on      = sel_q.irq_on;
  assign irq_no      = sel_q.irq_no;
  assign midi_irq    = sel_q.midi_irq;
  assign midi_base   = sel_q.midi_base;
  assign codec_mode  = sel_q.codec_mode;
  assign ext_mode    = sel_q.ext_mode;

endmodule

// File: rtl/audcfg_port_chk.sv
module audcfg_port_chk
  import audcfg_pkg::*;
#(
  parameter logic [CFG_AW-1:0] PW_ADDR    = 16'h0F8F,
  parameter logic [CFG_DW-1:0] CHIP_ID    = 8'hE4,
  parameter logic [CFG_AW-1:0] BASE_ORG   = 16'h0E0E,
  parameter logic [CFG_AW-1:0] FIXED_BASE = 16'h0F8E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] bus_addr,
  input logic [CFG_DW-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [CFG_DW-1:0] bus_rdata,
  input logic              unlocked,
  input logic              pw_req,
  input logic [CFG_AW-1:0] idx_base,
  input logic [CFG_AW-1:0] legacy_base,
  input logic [CFG_AW-1:0] codec_base,
  input logic [3:0]        irq_no,
  input logic [CFG_AW-1:0] midi_base,
  input logic              codec_mode
);

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PW_ADDR && bus_wdata == CHIP_ID) |=> unlocked);

  a_r3_relocate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PW_ADDR && unlocked) |=>
      (idx_base == BASE_ORG + {7'd0, $past(bus_wdata[4:0]), 4'd0}) &&
      (pw_req == !$past(bus_wdata[7])));

  a_r4_closed_reads_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !unlocked && pw_req) |-> (bus_rdata == 8'hFF));

  a_r6_data_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == idx_base + 16'd1 && idx_base != FIXED_BASE)
      |=> !unlocked);

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({legacy_base, codec_base, irq_no, midi_base, codec_mode}));

endmodule

bind audcfg_port audcfg_port_chk #(
  .PW_ADDR   (PW_ADDR),
  .CHIP_ID   (CHIP_ID),
  .BASE_ORG  (BASE_ORG),
  .FIXED_BASE(FIXED_BASE)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .unlocked   (unlocked),
  .pw_req     (pw_req),
  .idx_base   (idx_base),
  .legacy_base(legacy_base),
  .codec_base (codec_base),
  .irq_no     (irq_no),
  .midi_base  (midi_base),
  .codec_mode (codec_mode)
);

// File: tb/audcfg_port_tb_top.sv
`timescale 1ns/1ps
module audcfg_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_rdata;
  logic [7:0]  codec_status;
  logic [15:0] legacy_base, codec_base, midi_base;
  logic        game_en, dma_on, irq_on, codec_mode, ext_mode;
  logic [1:0]  dma_ch;
  logic [3:0]  irq_no, midi_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  audcfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .codec_status(codec_status), .legacy_base(legacy_base),
    .codec_base(codec_base), .game_en(game_en), .dma_on(dma_on),
    .dma_ch(dma_ch), .irq_on(irq_on), .irq_no(irq_no), .midi_irq(midi_irq),
    .midi_base(midi_base), .codec_mode(codec_mode), .ext_mode(ext_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  bit       m_unl;
  bit       m_req;
  bit [4:0] m_fld;
  bit [7:0] m_last;
  bit [7:0] m_idx;
  bit [7:0] m_reg [12];

  function automatic bit [15:0] m_base();
    return 16'h0E0E + {7'd0, m_fld, 4'd0};
  endfunction

  function automatic bit m_open();
    return m_unl || !m_req;
  endfunction

  function automatic bit [62:0] exp_dec();
    bit [15:0] lb, cb, mb;
    bit        ge, don, ion;
    bit [1:0]  dc;
    bit [3:0]  irq, mirq;
    lb = m_reg[0][7] ? 16'h0240 : 16'h0220;
    case (m_reg[0][5:4])
      0: cb = 16'h0530; 1: cb = 16'h0E80; 2: cb = 16'h0F40; default: cb = 16'h0604;
    endcase
    ge  = !m_reg[0][0];
    don = m_reg[2][1:0] != 0;
    case (m_reg[2][1:0]) 2: dc = 1; 3: dc = 3; default: dc = 0; endcase
    ion = m_reg[2][5:3] != 0;
    case (m_reg[2][5:3])
      0: irq = 0; 1: irq = 7; 2: irq = 9; 3: irq = 10; 4: irq = 11; default: irq = 5;
    endcase
    case (m_reg[5][4:3]) 0: mirq = 9; 1: mirq = 10; 2: mirq = 5; default: mirq = 7; endcase
    case (m_reg[5][6:5])
      0: mb = 16'h0330; 1: mb = 16'h0320; 2: mb = 16'h0310; default: mb = 16'h0300;
    endcase
    return {lb, cb, ge, don, dc, ion, irq, mirq, mb, m_reg[5][1], m_reg[4][5]};
  endfunction

  function automatic bit [7:0] exp_rd(bit [15:0] a);
    if (m_open() && a == m_base()) return m_idx;
    if (m_open() && a == m_base() + 16'd1) begin
      if (m_idx == 10) return {5'd0, codec_status[4], 2'd0};
      if (m_idx < 12)  return m_reg[m_idx];
    end
    return 8'hFF;
  endfunction

  task automatic m_reset();
    m_unl = 0; m_req = 1; m_fld = 0; m_last = 0; m_idx = 0;
    for (int i = 0; i < 12; i++) m_reg[i] = 8'h00;
    m_reg[2] = 8'h2A; m_reg[3] = 8'h10; m_reg[5] = 8'h81;
  endtask

  task automatic m_write(bit [15:0] a, bit [7:0] v);
    bit [15:0] b  = m_base();
    bit        op = m_open();
    bit [7:0]  ix = m_idx;
    if (a == 16'h0F8F) begin
      if (m_unl) begin m_fld = v[4:0]; m_req = !v[7]; m_unl = 0; end
      if (v == 8'hE4) m_unl = 1;
      else if (m_last != 8'hE4) m_unl = 0;
      m_last = v;
    end
    if (op && a == b) m_idx = v - 8'd1;
    if (a == b + 16'd1) begin
      if (op && ix < 12 && ix != 10) m_reg[ix] = v;
      if (b != 16'h0F8E) m_unl = 0;
    end
  endtask

  task automatic m_read(bit [15:0] a);
    if (a == m_base() + 16'd1 && m_base() != 16'h0F8E) m_unl = 0;
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(string req, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [62:0] dut_dec();
    return {legacy_base, codec_base, game_en, dma_on, dma_ch, irq_on, irq_no,
            midi_irq, midi_base, codec_mode, ext_mode};
  endfunction

  task automatic wr(bit [15:0] a, bit [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, v);
  endtask

  task automatic rd(bit [15:0] a, string req);
    bit [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    e = exp_rd(a);
    #1;
    chk(req, bus_rdata, e);
    @(negedge clk);
    bus_rd = 1'b0;
    m_read(a);
  endtask

  task automatic chk_dec(string req);
    chk(req, dut_dec(), exp_dec());
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    bit [15:0] hold;
    void'($urandom(32'h1F2E));
    bus_addr = 0; bus_wdata = 0; bus_rd = 0; bus_wr = 0;
    codec_status = 8'h00;
    rst_n = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state (decoded defaults and locked window)
    chk_dec("R1 reset decode");
    chk("R1 legacy 0x220", legacy_base, 16'h0220);
    chk("R1 irq 5", irq_no, 4'd5);
    rd(16'h0E0E, "R1/R4 locked index read");
    rd(16'h0F8F, "R4 key port reads high");

    // R2: wrong key keeps window closed
    wr(16'h0F8F, 8'h55);
    rd(16'h0E0F, "R2 wrong key stays locked");
    wr(16'h0E0E, 8'h03);      // ignored while locked
    wr(16'h0F8F, 8'hE4);
    rd(16'h0E0E, "R4 ignored index write, R2 open");

    // R5: index minus one and wrap
    wr(16'h0E0E, 8'h00);
    rd(16'h0E0E, "R5 index wraps to 0xFF");
    rd(16'h0E0F, "R7 index out of range reads 0xFF, R6 relock");
    rd(16'h0E0E, "R6 relocked after data read");

    // R8: register 0 write and decode timing
    wr(16'h0F8F, 8'hE4);
    wr(16'h0E0E, 8'h01);
    hold = legacy_base;
    @(negedge clk);
    bus_addr = 16'h0E0F; bus_wdata = 8'hB1; bus_wr = 1'b1;
    #1 chk("R11 no change before edge", legacy_base, hold);
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(16'h0E0F, 8'hB1);
    chk_dec("R8 reg0 0xB1 decode");
    chk("R8 codec base 0x604", codec_base, 16'h0604);
    chk("R8 game off", game_en, 1'b0);

    // R9/R10: register 2, 4, 5 through several codes
    for (int k = 0; k < 8; k++) begin
      wr(16'h0F8F, 8'hE4); wr(16'h0E0E, 8'h03); wr(16'h0E0F, 8'((k << 3) | (k & 3)));
      chk_dec("R9 irq/dma code sweep");
      wr(16'h0F8F, 8'hE4); wr(16'h0E0E, 8'h06);
      wr(16'h0E0F, 8'(((k & 3) << 5) | (((k + 1) & 3) << 3) | ((k & 1) << 1)));
      chk_dec("R10 midi sweep");
    end
    wr(16'h0F8F, 8'hE4); wr(16'h0E0E, 8'h05); wr(16'h0E0F, 8'h20);
    chk("R10 ext mode", ext_mode, 1'b1);

    // R7: read-only index 10 with status bit, write dropped
    codec_status = 8'h10;
    wr(16'h0F8F, 8'hE4); wr(16'h0E0E, 8'h0B); wr(16'h0E0F, 8'hFF);
    wr(16'h0F8F, 8'hE4); rd(16'h0E0F, "R7 index 10 status bit set");
    codec_status = 8'hEF;
    wr(16'h0F8F, 8'hE4); rd(16'h0E0F, "R7 index 10 status bit clear");

    // R3: relocate to 0x0F8E (field 0x18) with key still required
    wr(16'h0F8F, 8'hE4); wr(16'h0F8F, 8'h18);
    rd(16'h0F8E, "R3 relocated window locked");
    wr(16'h0F8F, 8'hE4);
    wr(16'h0F8E, 8'h02);
    rd(16'h0F8F, "R6 no relock at 0x0F8E (1)");
    rd(16'h0F8F, "R6 no relock at 0x0F8E (2)");
    rd(16'h0F8E, "R6 window still open at 0x0F8E");

    // R2/R3: key written while open relocates to 0x0E4E and bypasses key
    wr(16'h0F8F, 8'hE4);
    rd(16'h0E4E, "R3 key while open moves to 0x0E4E");
    rd(16'h0E4F, "R4 bypass keeps data port open");
    rd(16'h0E4E, "R4 bypass after data read");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 9);
      codec_status = 8'($urandom);
      case (op)
        0, 1:    wr(16'h0F8F, 8'hE4);
        2:       wr(16'h0F8F, 8'($urandom));
        3:       wr(16'h0F8F, {1'($urandom), 2'd0, 5'($urandom)});
        4:       wr(m_base(), 8'($urandom_range(0, 13)));
        5:       wr(m_base() + 16'd1, 8'($urandom));
        6:       rd(m_base(), "R5 random index read");
        7:       rd(m_base() + 16'd1, "R7 random data read");
        8:       rd(16'($urandom), "R4 random address read");
        default: wr(16'($urandom), 8'($urandom));
      endcase
      chk_dec("R11 random decode");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule